// File: doc/BRIEF.md
# SMBus Target Command Bridge

This block sits behind an SMBus target byte engine. It turns the byte stream of one or more SMBus write transactions into a single internal register or memory access. For reads, it returns the fetched data to the host in a later read transaction. The byte engine reports each received byte, each start or repeated start addressed to this target (with its direction), each stop, and each request for a byte to transmit. The bridge answers every start and every received byte with an ACK/NACK decision one cycle later. It drives the byte to transmit. While read data is not yet back from the internal fabric, it holds the bus by clock stretching.

An overall transfer opens with a command byte that has the begin flag set and closes with the transaction whose command byte has the end flag set. Each write transaction carries a command byte, an optional byte count and a payload chunk. The chunks, joined in order, form four address bytes followed, for writes, by one to four data bytes. Two address layouts exist. A configuration access holds bus, device/function, a four-bit extended offset and a register offset. A memory access holds a region byte, a zero filler byte and a 16-bit offset. The bridge NACKs all traffic while an internal write is outstanding.

Top module: `smbus_cmd_bridge`

## Requirements
- R1: A command byte is laid out as bit7 begin, bit6 end, bit5 memory (1) / configuration (0), bit4 write (1) / read (0), bits1:0 size (0 byte, 1 word, 2 block). Size code 3 is NACKed, and the rest of that transaction is refused.
- R2: For a write, once the closing transaction ends, req_valid rises with req_write=1. req_addr carries the four address bytes, the first received in bits 31:24. req_wdata holds data byte k in bits 8k+7:8k. req_len equals the number of data bytes.
- R3: In a configuration access, the third address byte must have its upper nibble at zero; otherwise that byte is NACKed.
- R4: In a memory access, the second address byte (filler) must be zero; otherwise that byte is NACKed.
- R5: While an internal write is outstanding (req_valid high, before resp_valid), every start and every received byte gets ack_valid=1 with ack=0.
- R6: A byte-size command carries exactly one payload byte per transaction and a word-size command exactly two. A payload byte beyond that count is NACKed and the transfer is discarded.
- R7: For block size, the byte after the command is a count. A count of 0 or above 4 is NACKed, the transfer is discarded, and no request is issued.
- R8: A command without the begin flag outside an open transfer is NACKed. No request is issued until a transaction whose command has the end flag closes with a stop or repeated start.
- R9: After a read command closes with exactly four address bytes, a read-direction start is ACKed. It raises req_valid with req_write=0 and req_len of 1, 2 or 4 for byte, word or block. hold stays high until the cycle after resp_valid.
- R10: Read data is returned least significant byte first: one byte for byte size, two for word size. For block size the count 4 comes first, followed by four data bytes. Every byte requested beyond the sequence is 0xFF.
- R11: A stop or start that arrives before a transaction's expected bytes are complete discards the transfer. A read-direction start with no completed read command pending is NACKed.
- R12: After reset, ack_valid, req_valid and hold are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start or repeated start addressed to this target |
| bus_rd | input | 1 | Direction of that start, 1 = read |
| bus_stop | input | 1 | Stop condition seen |
| rx_valid | input | 1 | A byte was received from the host |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | Host consumed the current transmit byte |
| resp_valid | input | 1 | Internal fabric completes the request |
| resp_rdata | input | 32 | Internal read data |
| ack_valid | output | 1 | ACK decision is valid |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| tx_data | output | 8 | Byte to transmit |
| hold | output | 1 | Stretch the clock |
| req_valid | output | 1 | Internal request outstanding |
| req_write | output | 1 | Request is a write |
| req_mem | output | 1 | Request uses the memory layout |
| req_addr | output | 32 | Four address bytes |
| req_wdata | output | 32 | Write data, byte 0 lowest |
| req_len | output | 3 | Data byte count |

## Verification
On every cycle, the assertions check the following. Busy traffic is refused. An out-of-range count and a non-zero filler are NACKed on the next cycle. The request fields stay still while the request is outstanding. A write request rises only at the close of a transaction. The stretch holds until the response and drops right after it. Only the bench scenarios can show the joining of split chunks into the right address and data, the begin/end bookkeeping, discarding on early stop, and the exact order and padding of the returned bytes. The bench drives these with random chunk splits and size choices, alongside directed error cases.

// File: rtl/smbcb_pkg.sv
package smbcb_pkg;

    localparam int ADDR_BYTES = 4;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_BLOCK = 2'd2,
        SZ_RSVD  = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic       first_b;
        logic       last_b;
        logic       mem_sel;
        logic       wr_op;
        logic [1:0] spare;
        xfer_size_e size;
    } cmd_byte_t;

    typedef enum logic [3:0] {
        PS_IDLE, PS_CMD, PS_CNT, PS_PAY, PS_DONE,
        PS_DROP, PS_WBUSY, PS_RREQ, PS_RDATA
    } pstate_e;

    function automatic int unsigned chunk_len(xfer_size_e s);
        return (s == SZ_WORD) ? 2 : 1;
    endfunction

    function automatic int unsigned read_len(xfer_size_e s, int unsigned blk);
        case (s)
            SZ_BYTE: return 1;
            SZ_WORD: return 2;
            default: return blk;
        endcase
    endfunction

endpackage

// File: rtl/smbcb_frame_parser.sv
module smbcb_frame_parser
    import smbcb_pkg::*;
#(
    parameter int MAX_BLOCK = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_start,
    input  logic                   bus_rd,
    input  logic                   bus_stop,
    input  logic                   rx_valid,
    input  logic [7:0]             rx_data,
    input  logic                   resp_valid,
    output logic                   ack_valid,
    output logic                   ack,
    output logic                   req_valid,
    output logic                   req_write,
    output logic                   req_mem,
    output logic [8*ADDR_BYTES-1:0] req_addr,
    output logic [8*MAX_BLOCK-1:0] req_wdata,
    output logic [$clog2(MAX_BLOCK+1)-1:0] req_len,
    output xfer_size_e             rd_size,
    output logic                   read_wait,
    output logic                   read_active
);
    localparam int BUF_N = ADDR_BYTES + MAX_BLOCK;
    localparam int IDX_W = $clog2(BUF_N + 1);
    localparam int LEN_W = $clog2(MAX_BLOCK + 1);
    localparam logic [IDX_W-1:0] ADDR_N  = IDX_W'(ADDR_BYTES);
    localparam logic [IDX_W-1:0] BUF_LIM = IDX_W'(BUF_N);
    localparam logic [7:0]       CNT_MAX = 8'(MAX_BLOCK);

    pstate_e                  st;
    logic                     in_xfer, armed, op_write, op_mem, last_q;
    xfer_size_e               size_q;
    logic [LEN_W-1:0]         rem;
    logic [IDX_W-1:0]         idx;
    logic [BUF_N-1:0][7:0]    abuf;

    cmd_byte_t cb;
    logic bus_evt, closing, close_rd, close_wr, partial, armed_eff;
    logic cmd_bad, cnt_bad, pay_bad;
    logic [IDX_W-1:0] lim;

    always_comb begin
        cb        = cmd_byte_t'(rx_data);
        bus_evt   = bus_start | bus_stop;
        closing   = (st == PS_DONE) && bus_evt;
        close_rd  = closing && last_q && !op_write && (idx == ADDR_N);
        close_wr  = closing && last_q && op_write && (idx > ADDR_N);
        partial   = bus_evt && (st == PS_CMD || st == PS_CNT || st == PS_PAY);
        armed_eff = (armed || close_rd) && !partial;
        cmd_bad   = (cb.size == SZ_RSVD) || (!cb.first_b && !in_xfer);
        cnt_bad   = (rx_data == 8'd0) || (rx_data > CNT_MAX);
        lim       = op_write ? BUF_LIM : ADDR_N;
        pay_bad   = (idx >= lim)
                  || (op_mem && idx == IDX_W'(1) && rx_data != 8'd0)
                  || (!op_mem && idx == IDX_W'(2) && rx_data[7:4] != 4'd0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= PS_IDLE; in_xfer <= 1'b0; armed <= 1'b0;
            op_write <= 1'b0; op_mem <= 1'b0; last_q <= 1'b0;
            size_q <= SZ_BYTE; rem <= '0; idx <= '0; abuf <= '0;
            ack_valid <= 1'b0; ack <= 1'b0;
        end else begin
            ack_valid <= 1'b0;
            ack       <= 1'b0;
            case (st)
                PS_WBUSY: begin
                    if (bus_start || rx_valid) ack_valid <= 1'b1;
                    if (resp_valid) st <= PS_IDLE;
                end
                PS_RREQ: if (resp_valid) st <= PS_RDATA;
                default: begin
                    if (bus_evt) begin
                        if (partial || st == PS_RDATA) begin
                            in_xfer <= 1'b0;
                            armed   <= 1'b0;
                        end
                        if (closing && last_q) begin
                            in_xfer <= 1'b0;
                            armed   <= close_rd;
                        end
                        if (close_wr) begin
                            st <= PS_WBUSY;
                            if (bus_start) ack_valid <= 1'b1;
                        end else if (bus_start) begin
                            ack_valid <= 1'b1;
                            if (bus_rd) begin
                                if (armed_eff) begin
                                    ack <= 1'b1; st <= PS_RREQ; armed <= 1'b0;
                                end else begin
                                    st <= PS_DROP;
                                end
                            end else begin
                                ack <= 1'b1; st <= PS_CMD;
                            end
                        end else begin
                            st <= PS_IDLE;
                        end
                    end else if (rx_valid) begin
                        ack_valid <= 1'b1;
                        case (st)
                            PS_CMD: begin
                                if (cmd_bad) begin
                                    st <= PS_DROP; in_xfer <= 1'b0; armed <= 1'b0;
                                end else begin
                                    ack    <= 1'b1;
                                    last_q <= cb.last_b;
                                    size_q <= cb.size;
                                    if (cb.first_b) begin
                                        idx <= '0; op_write <= cb.wr_op; op_mem <= cb.mem_sel;
                                        in_xfer <= 1'b1; armed <= 1'b0;
                                    end
                                    if (cb.size == SZ_BLOCK) st <= PS_CNT;
                                    else begin
                                        rem <= LEN_W'(chunk_len(cb.size));
                                        st  <= PS_PAY;
                                    end
                                end
                            end
                            PS_CNT: begin
                                if (cnt_bad) begin
                                    st <= PS_DROP; in_xfer <= 1'b0; armed <= 1'b0;
                                end else begin
                                    ack <= 1'b1; rem <= rx_data[LEN_W-1:0]; st <= PS_PAY;
                                end
                            end
                            PS_PAY: begin
                                if (pay_bad) begin
                                    st <= PS_DROP; in_xfer <= 1'b0; armed <= 1'b0;
                                end else begin
                                    ack       <= 1'b1;
                                    abuf[idx] <= rx_data;
                                    idx       <= idx + 1'b1;
                                    rem       <= rem - 1'b1;
                                    if (rem == LEN_W'(1)) st <= PS_DONE;
                                end
                            end
                            default: begin
                                st <= PS_DROP; in_xfer <= 1'b0; armed <= 1'b0;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
        assign req_addr[8*(ADDR_BYTES-1-g) +: 8] = abuf[g];
    end
    for (genvar g = 0; g < MAX_BLOCK; g++) begin : g_wdata
        assign req_wdata[8*g +: 8] = abuf[ADDR_BYTES+g];
    end

    assign req_valid   = (st == PS_WBUSY) || (st == PS_RREQ);
    assign req_write   = op_write;
    assign req_mem     = op_mem;
    assign req_len     = op_write ? LEN_W'(idx - ADDR_N) : LEN_W'(read_len(size_q, MAX_BLOCK));
    assign rd_size     = size_q;
    assign read_wait   = (st == PS_RREQ);
    assign read_active = (st == PS_RDATA);

    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (rst)
        (st == PS_WBUSY && (bus_start || rx_valid)) |=> (ack_valid && !ack)); // R5
    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
        (st == PS_CNT && rx_valid && !bus_evt && cnt_bad) |=> (ack_valid && !ack && !req_valid)); // R7
    AST_FILLER_NACK: assert property (@(posedge clk) disable iff (rst)
        (st == PS_PAY && rx_valid && !bus_evt && op_mem && idx == IDX_W'(1) && rx_data != 8'd0)
        |=> (ack_valid && !ack)); // R4
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !resp_valid) |=> (req_valid && $stable(req_addr) && $stable(req_write))); // R2
    AST_WRITE_ON_CLOSE: assert property (@(posedge clk) disable iff (rst)
        ($rose(req_valid) && req_write) |-> $past(bus_stop || bus_start)); // R8

endmodule

// File: rtl/smbcb_tx_return.sv
module smbcb_tx_return
    import smbcb_pkg::*;
#(
    parameter int MAX_BLOCK = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic                   active,
    input  logic                   tx_req,
    input  xfer_size_e             size,
    input  logic [8*MAX_BLOCK-1:0] rdata,
    output logic [7:0]             tx_data
);
    localparam int SEQ_N = MAX_BLOCK + 1;
    localparam int POS_W = $clog2(SEQ_N + 1);

    logic [SEQ_N-1:0][7:0] seq_q;
    logic [POS_W-1:0]      pos_q, len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0; pos_q <= '0; len_q <= '0;
        end else if (load) begin
            pos_q <= '0;
            if (size == SZ_BLOCK) begin
                seq_q[0] <= 8'(MAX_BLOCK);
                for (int k = 0; k < MAX_BLOCK; k++) seq_q[k+1] <= rdata[8*k +: 8];
                len_q <= POS_W'(SEQ_N);
            end else begin
                for (int k = 0; k < MAX_BLOCK; k++) seq_q[k] <= rdata[8*k +: 8];
                seq_q[SEQ_N-1] <= 8'hFF;
                len_q <= POS_W'(read_len(size, MAX_BLOCK));
            end
        end else if (active && tx_req && pos_q < len_q) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign tx_data = (active && pos_q < len_q) ? seq_q[pos_q] : 8'hFF;

endmodule

// File: rtl/smbus_cmd_bridge.sv
module smbus_cmd_bridge
    import smbcb_pkg::*;
#(
    parameter int MAX_BLOCK = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_start,
    input  logic                           bus_rd,
    input  logic                           bus_stop,
    input  logic                           rx_valid,
    input  logic [7:0]                     rx_data,
    input  logic                           tx_req,
    input  logic                           resp_valid,
    input  logic [8*MAX_BLOCK-1:0]         resp_rdata,
    output logic                           ack_valid,
    output logic                           ack,
    output logic [7:0]                     tx_data,
    output logic                           hold,
    output logic                           req_valid,
    output logic                           req_write,
    output logic                           req_mem,
    output logic [8*ADDR_BYTES-1:0]        req_addr,
    output logic [8*MAX_BLOCK-1:0]         req_wdata,
    output logic [$clog2(MAX_BLOCK+1)-1:0] req_len
);
    xfer_size_e rd_size;
    logic       read_wait, read_active;

    smbcb_frame_parser #(.MAX_BLOCK(MAX_BLOCK)) u_parse (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_rd(bus_rd),
        .bus_stop(bus_stop), .rx_valid(rx_valid), .rx_data(rx_data),
        .resp_valid(resp_valid), .ack_valid(ack_valid), .ack(ack),
        .req_valid(req_valid), .req_write(req_write), .req_mem(req_mem),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
        .rd_size(rd_size), .read_wait(read_wait), .read_active(read_active)
    );

    smbcb_tx_return #(.MAX_BLOCK(MAX_BLOCK)) u_tx (
        .clk(clk), .rst(rst), .load(read_wait && resp_valid),
        .active(read_active), .tx_req(tx_req), .size(rd_size),
        .rdata(resp_rdata), .tx_data(tx_data)
    );

    assign hold = read_wait;

    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (rst)
        (hold && !resp_valid) |=> hold); // R9
    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (hold && resp_valid) |=> !hold); // R9
    AST_HOLD_IS_READ: assert property (@(posedge clk) disable iff (rst)
        hold |-> (req_valid && !req_write)); // R9

endmodule

// File: tb/sim_smbus_cmd_bridge.sv
module sim_smbus_cmd_bridge;
    import smbcb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_start = 0, bus_rd = 0, bus_stop = 0, rx_valid = 0, tx_req = 0, resp_valid = 0;
    logic [7:0]  rx_data = '0;
    logic [31:0] resp_rdata = '0;
    logic ack_valid, ack, hold, req_valid, req_write, req_mem;
    logic [7:0]  tx_data;
    logic [31:0] req_addr, req_wdata;
    logic [2:0]  req_len;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] pl [8];

    always #5 clk = ~clk;

    smbus_cmd_bridge u0 (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_rd(bus_rd), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_req(tx_req), .resp_valid(resp_valid),
        .resp_rdata(resp_rdata), .ack_valid(ack_valid), .ack(ack), .tx_data(tx_data),
        .hold(hold), .req_valid(req_valid), .req_write(req_write), .req_mem(req_mem),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len)
    );

    function automatic logic [31:0] mem_model(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
    endfunction

    function automatic logic [7:0] cmd(logic f, logic l, logic m, logic w, xfer_size_e s);
        return {f, l, m, w, 2'b00, s};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bstart(input logic rd, output logic a);
        bus_start = 1'b1; bus_rd = rd;
        @(negedge clk);
        bus_start = 1'b0; bus_rd = 1'b0;
        a = ack_valid & ack;
    endtask

    task automatic bbyte(input logic [7:0] b, output logic a);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
        a = ack_valid & ack;
    endtask

    task automatic bstop();
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
    endtask

    // one write-direction transaction carrying pl[off .. off+n-1]; no closing event
    task automatic chunk(input logic f, input logic l, input logic m, input logic w,
                         input xfer_size_e s, input int off, input int n, output logic ok);
        logic a;
        ok = 1'b1;
        bstart(1'b0, a); ok &= a;
        bbyte(cmd(f, l, m, w, s), a); ok &= a;
        if (s == SZ_BLOCK) begin bbyte(8'(n), a); ok &= a; end
        for (int i = 0; i < n; i++) begin bbyte(pl[off+i], a); ok &= a; end
    endtask

    function automatic xfer_size_e pick_size(int len);
        if (len == 1) return ($urandom % 2) ? SZ_BYTE : SZ_BLOCK;
        if (len == 2) return ($urandom % 2) ? SZ_WORD : SZ_BLOCK;
        return SZ_BLOCK;
    endfunction

    function automatic void fill_addr(logic m);
        for (int i = 0; i < 4; i++) pl[i] = 8'($urandom);
        if (m) pl[1] = 8'h00;
        else   pl[2][7:4] = 4'h0;
    endfunction

    task automatic serve(input int lat, input logic [31:0] rd);
        for (int i = 0; i < lat; i++) @(negedge clk);
        resp_rdata = rd; resp_valid = 1'b1;
        @(negedge clk);
        resp_valid = 1'b0;
    endtask

    task automatic do_write(input logic m, input int nd);
        int off, len, total;
        logic ok;
        logic [31:0] mask;
        fill_addr(m);
        for (int i = 4; i < 8; i++) pl[i] = 8'($urandom);
        total = 4 + nd;
        off = 0;
        while (off < total) begin
            len = 1 + ($urandom % (((total - off) < 4) ? (total - off) : 4));
            chunk(off == 0, off + len == total, m, 1'b1, pick_size(len), off, len, ok);
            chk("R2 write chunk acked", 32'(ok), 32'd1);
            off += len;
            bstop();
            if (off < total) chk("R8 no request before end", 32'(req_valid), 32'd0);
        end
        chk("R2 req_valid", 32'(req_valid), 32'd1);
        chk("R2 req_write", 32'(req_write), 32'd1);
        chk("R2 req_mem", 32'(req_mem), 32'(m));
        chk("R2 req_addr", req_addr, {pl[0], pl[1], pl[2], pl[3]});
        chk("R2 req_len", 32'(req_len), 32'(nd));
        mask = (nd == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nd)) - 1);
        chk("R2 req_wdata", req_wdata & mask, {pl[7], pl[6], pl[5], pl[4]} & mask);
        if ($urandom % 2) begin
            bstart(1'b0, ok);
            chk("R5 start while busy NACKed", 32'(ok), 32'd0);
            bbyte(8'hC2, ok);
            chk("R5 byte while busy NACKed", 32'(ok), 32'd0);
            bstop();
        end
        serve(1 + ($urandom % 4), 32'h0);
        chk("R2 request retired", 32'(req_valid), 32'd0);
    endtask

    task automatic do_read(input logic m, input xfer_size_e rs, input logic by_start);
        int off, len, last_len, nexp;
        logic ok;
        logic [31:0] addr, rd;
        logic [7:0] exp_seq [6];
        fill_addr(m);
        last_len = (rs == SZ_BYTE) ? 1 : (rs == SZ_WORD) ? 2 : 1 + ($urandom % 4);
        off = 0;
        while (off < 4 - last_len) begin
            len = 1 + ($urandom % (4 - last_len - off));
            chunk(off == 0, 1'b0, m, 1'b0, pick_size(len), off, len, ok);
            chk("R8 read address chunk acked", 32'(ok), 32'd1);
            off += len;
            bstop();
        end
        chunk(off == 0, 1'b1, m, 1'b0, rs, off, last_len, ok);
        chk("R1 final read chunk acked", 32'(ok), 32'd1);
        if (!by_start) bstop();
        bstart(1'b1, ok);
        addr = {pl[0], pl[1], pl[2], pl[3]};
        chk("R9 read start acked", 32'(ok), 32'd1);
        chk("R9 hold raised", 32'(hold), 32'd1);
        chk("R9 read request", {30'd0, req_valid, req_write}, 32'd2);
        chk("R9 read address", req_addr, addr);
        chk("R9 read length", 32'(req_len), (rs == SZ_BYTE) ? 1 : (rs == SZ_WORD) ? 2 : 4);
        rd = mem_model(addr);
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk("R9 hold kept while waiting", 32'(hold), 32'd1);
        serve(0, rd);
        chk("R9 hold released", 32'(hold), 32'd0);
        if (rs == SZ_BLOCK) begin
            exp_seq[0] = 8'd4;
            for (int i = 0; i < 4; i++) exp_seq[i+1] = rd[8*i +: 8];
            nexp = 5;
        end else begin
            nexp = (rs == SZ_BYTE) ? 1 : 2;
            for (int i = 0; i < nexp; i++) exp_seq[i] = rd[8*i +: 8];
        end
        exp_seq[nexp] = 8'hFF;
        for (int i = 0; i <= nexp; i++) begin
            chk((i == nexp) ? "R10 pad byte" : "R10 read byte", 32'(tx_data), 32'(exp_seq[i]));
            tx_req = 1'b1;
            @(negedge clk);
            tx_req = 1'b0;
        end
        bstop();
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic a;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 reset ack_valid", 32'(ack_valid), 32'd0);
        chk("R12 reset req_valid", 32'(req_valid), 32'd0);
        chk("R12 reset hold", 32'(hold), 32'd0);

        // reserved size code
        bstart(1'b0, a);
        bbyte(8'hD3, a);
        chk("R1 reserved size NACK", 32'(a), 32'd0);
        bstop();

        // byte count 0 and 5
        bstart(1'b0, a); bbyte(cmd(1, 1, 1, 1, SZ_BLOCK), a); bbyte(8'd0, a);
        chk("R7 count zero NACK", 32'(a), 32'd0);
        bstop();
        chk("R7 no request after zero count", 32'(req_valid), 32'd0);
        bstart(1'b0, a); bbyte(cmd(1, 1, 0, 1, SZ_BLOCK), a); bbyte(8'd5, a);
        chk("R7 count five NACK", 32'(a), 32'd0);
        bstop();
        chk("R7 no request after count five", 32'(req_valid), 32'd0);

        // memory filler non-zero
        bstart(1'b0, a); bbyte(cmd(1, 1, 1, 1, SZ_BLOCK), a); bbyte(8'd4, a);
        bbyte(8'h12, a); bbyte(8'h01, a);
        chk("R4 filler nonzero NACK", 32'(a), 32'd0);
        bstop();

        // configuration extended offset nibble
        bstart(1'b0, a); bbyte(cmd(1, 1, 0, 1, SZ_BLOCK), a); bbyte(8'd4, a);
        bbyte(8'h01, a); bbyte(8'h08, a); bbyte(8'h30, a);
        chk("R3 extended offset overflow NACK", 32'(a), 32'd0);
        bstop();

        // continuation without open transfer
        bstart(1'b0, a); bbyte(cmd(0, 1, 0, 1, SZ_BYTE), a);
        chk("R8 continuation without begin NACK", 32'(a), 32'd0);
        bstop();

        // extra byte in a word transaction
        bstart(1'b0, a); bbyte(cmd(1, 0, 1, 0, SZ_WORD), a);
        bbyte(8'h40, a); bbyte(8'h00, a);
        chk("R6 word bytes acked", 32'(a), 32'd1);
        bbyte(8'h77, a);
        chk("R6 third word byte NACK", 32'(a), 32'd0);
        bstop();
        chk("R6 no request after overrun", 32'(req_valid), 32'd0);

        // partial abort of a read command, then read start refused
        bstart(1'b0, a); bbyte(cmd(1, 1, 1, 0, SZ_BLOCK), a); bbyte(8'd4, a);
        bbyte(8'h20, a); bbyte(8'h00, a);
        bstop();
        bstart(1'b1, a);
        chk("R11 read after partial abort NACK", 32'(a), 32'd0);
        chk("R11 no request after abort", 32'(req_valid), 32'd0);
        bstop();
        bstart(1'b1, a);
        chk("R11 unarmed read start NACK", 32'(a), 32'd0);
        bstop();

        // directed full block read and single-byte write
        do_read(1'b1, SZ_BLOCK, 1'b0);
        do_write(1'b0, 1);

        // random mix
        for (int it = 0; it < 40; it++) begin
            if ($urandom % 2) do_write(1'($urandom), 1 + ($urandom % 4));
            else do_read(1'($urandom), xfer_size_e'($urandom % 3), 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule